// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a segment base and an offset into a physical memory address for a small segmented memory model. It keeps four segment registers (code, data, stack, extra) and six offset registers: the instruction pointer, the stack pointer, the base pointer, the base register and the source and destination index pointers. The caller names an access kind each cycle. The block chooses that kind's default segment and offset, presents the physical address combinationally in the same cycle, and updates the pointer the access consumes at the next clock edge.

A fetch advances the instruction pointer. A push or pop moves the stack pointer by a word. A string access steps its index pointer by one element, upward or downward as a direction input selects. A synchronous write port loads any register, and a combinational read port returns any register, so the block can be set up and inspected without any further bus logic.

Top module: `seg_agu`

## Requirements
- R1: `phys_addr` equals (segment × 16 + offset) modulo 2^20 for every valid access of kinds 0 to 6. For example, segment FFFF with offset FFFF gives 0FFEF.
- R2: Kind 0 (fetch) addresses code:IP. After the edge, IP is IP+1 modulo 2^16.
- R3: Kind 1 (push) addresses stack:(SP−2) and leaves SP−2. Kind 2 (pop) addresses stack:SP and leaves SP+2. Both wrap modulo 2^16.
- R4: Kind 3 (based) addresses stack:BP. Kind 4 (data) addresses data:BX. Neither kind changes any register.
- R5: Kind 5 (string source) addresses data:SI and steps SI. Kind 6 (string destination) addresses extra:DI and steps DI. The step is 1 when `acc_word`=0 and 2 when `acc_word`=1.
- R6: With `dir_down`=0 the string pointer steps upward, and with `dir_down`=1 it steps downward, both modulo 2^16.
- R7: After reset, CS reads FFFF and every other register reads 0, so a fetch addresses FFFF0. Kind 7, or `acc_valid`=0, gives `phys_addr`=0 and changes no register.
- R8: With `wr_en`=1, the register coded by `wr_sel` takes `wr_data` at the edge. Codes are 0 CS, 1 DS, 2 SS, 3 ES, 4 IP, 5 SP, 6 BP, 7 SI, 8 DI, 9 BX. A write takes priority over an automatic update of the same register. Codes 10 to 15 write nothing.
- R9: `rd_data` returns the register coded by `rd_sel` using the R8 codes, and returns 0 for codes 10 to 15. With neither an access nor a write, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_valid | input | 1 | An access is requested this cycle |
| acc_kind | input | 3 | Access kind, 0 to 7 as in R2 to R7 |
| acc_word | input | 1 | String element size: 1 selects a word, 0 a byte |
| dir_down | input | 1 | String direction: 1 steps downward |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register code to write |
| wr_data | input | 16 | Value to write |
| rd_sel | input | 4 | Register code to read |
| rd_data | output | 16 | Value of the selected register |
| phys_addr | output | 20 | Physical address of the current access |

## Verification
Random sequences mix all eight access kinds with occasional writes. A shadow register model predicts every address and every register, which tells apart a wrong default segment from a wrong offset and a wrong step. Directed cases preload pointers at 0 and FFFF so that wrap-around of the offsets and of the 20-bit sum is exercised, and a write that lands on IP during a fetch separates the priority order from the plain increment. Runs with the direction input at each value, and with byte and word elements, show whether the sign and the size of the string step are right.

// File: rtl/seg_agu_pkg.sv
`timescale 1ns/1ps
package seg_agu_pkg;
  typedef enum logic [2:0] {
    AK_FETCH = 3'd0, AK_PUSH = 3'd1, AK_POP = 3'd2, AK_BASED = 3'd3,
    AK_DATA  = 3'd4, AK_SRC  = 3'd5, AK_DST = 3'd6, AK_NONE  = 3'd7
  } acc_kind_e;

  localparam int NREG  = 10;
  localparam int SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    RG_CS = 4'd0, RG_DS = 4'd1, RG_SS = 4'd2, RG_ES = 4'd3, RG_IP = 4'd4,
    RG_SP = 4'd5, RG_BP = 4'd6, RG_SI = 4'd7, RG_DI = 4'd8, RG_BX = 4'd9
  } reg_id_e;
endpackage

// File: rtl/seg_agu_route.sv
`timescale 1ns/1ps
// Picks default segment/offset for an access and the single pointer update it implies.
module seg_agu_route
  import seg_agu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             acc_valid,
  input  logic [2:0]       acc_kind,
  input  logic             acc_word,
  input  logic             dir_down,
  input  logic [NREG*W-1:0] regs_flat,
  output logic [W-1:0]     seg_val,
  output logic [W-1:0]     off_val,
  output logic             upd_en,
  output logic [SEL_W-1:0] upd_sel,
  output logic [W-1:0]     upd_val
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  logic [W-1:0] r_cs, r_ds, r_ss, r_es, r_ip, r_sp, r_bp, r_si, r_di, r_bx;
  logic [W-1:0] str_step;
  acc_kind_e    kind;

  assign r_cs = regs_flat[RG_CS*W +: W];
  assign r_ds = regs_flat[RG_DS*W +: W];
  assign r_ss = regs_flat[RG_SS*W +: W];
  assign r_es = regs_flat[RG_ES*W +: W];
  assign r_ip = regs_flat[RG_IP*W +: W];
  assign r_sp = regs_flat[RG_SP*W +: W];
  assign r_bp = regs_flat[RG_BP*W +: W];
  assign r_si = regs_flat[RG_SI*W +: W];
  assign r_di = regs_flat[RG_DI*W +: W];
  assign r_bx = regs_flat[RG_BX*W +: W];

  assign kind     = acc_kind_e'(acc_kind);
  assign str_step = acc_word ? TWO : ONE;

  always_comb begin
    seg_val = '0;
    off_val = '0;
    upd_en  = 1'b0;
    upd_sel = RG_IP;
    upd_val = '0;
    if (acc_valid) begin
      unique case (kind)
        AK_FETCH: begin
          seg_val = r_cs; off_val = r_ip;
          upd_en = 1'b1; upd_sel = RG_IP; upd_val = r_ip + ONE;
        end
        AK_PUSH: begin
          seg_val = r_ss; off_val = r_sp - TWO;
          upd_en = 1'b1; upd_sel = RG_SP; upd_val = r_sp - TWO;
        end
        AK_POP: begin
          seg_val = r_ss; off_val = r_sp;
          upd_en = 1'b1; upd_sel = RG_SP; upd_val = r_sp + TWO;
        end
        AK_BASED: begin
          seg_val = r_ss; off_val = r_bp;
        end
        AK_DATA: begin
          seg_val = r_ds; off_val = r_bx;
        end
        AK_SRC: begin
          seg_val = r_ds; off_val = r_si;
          upd_en = 1'b1; upd_sel = RG_SI;
          upd_val = dir_down ? r_si - str_step : r_si + str_step;
        end
        AK_DST: begin
          seg_val = r_es; off_val = r_di;
          upd_en = 1'b1; upd_sel = RG_DI;
          upd_val = dir_down ? r_di - str_step : r_di + str_step;
        end
        default: begin
          seg_val = '0; off_val = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/seg_agu_regs.sv
`timescale 1ns/1ps
// Register bank: write port first, then the automatic pointer update, else hold.
module seg_agu_regs
  import seg_agu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_ok_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [W-1:0]      wr_data,
  input  logic              upd_en,
  input  logic [SEL_W-1:0]  upd_sel,
  input  logic [W-1:0]      upd_val,
  output logic [NREG*W-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [W-1:0] RST_VAL = (g == int'(RG_CS)) ? '1 : '0;
    logic [W-1:0] q, d;
    logic         en;

    always_comb begin
      en = 1'b0;
      d  = q;
      if (wr_en && (wr_sel == SEL_W'(g))) begin
        en = 1'b1;
        d  = wr_data;
      end else if (upd_en && (upd_sel == SEL_W'(g))) begin
        en = 1'b1;
        d  = upd_val;
      end
    end

    always_ff @(posedge clk or negedge rst_ok_n) begin
      if (!rst_ok_n) q <= RST_VAL;
      else if (en)   q <= d;
    end

    assign regs_flat[g*W +: W] = q;
  end
endmodule

// File: rtl/seg_agu_addr.sv
`timescale 1ns/1ps
// Shift-and-add of segment and offset, truncated to the address width.
module seg_agu_addr #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = SEG_W + SHIFT
) (
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  off_val,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] base, ofs;
  assign base = {seg_val, {SHIFT{1'b0}}};
  assign ofs  = ADDR_W'(off_val);
  assign addr = base + ofs;
endmodule

// File: rtl/seg_agu.sv
`timescale 1ns/1ps
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int W     = 16,
  parameter int SHIFT = 4,
  localparam int ADDR_W = W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [2:0]        acc_kind,
  input  logic              acc_word,
  input  logic              dir_down,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [W-1:0]      wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [W-1:0]      rd_data,
  output logic [ADDR_W-1:0] phys_addr
);
  logic [1:0]        rst_sync;
  logic              rst_ok_n;
  logic [NREG*W-1:0] regs_flat;
  logic [W-1:0]      seg_val, off_val, upd_val;
  logic              upd_en;
  logic [SEL_W-1:0]  upd_sel;
  logic [W-1:0]      ip_w, sp_w, si_w, di_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  seg_agu_route #(.W(W)) u_route (
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_word(acc_word),
    .dir_down(dir_down), .regs_flat(regs_flat), .seg_val(seg_val),
    .off_val(off_val), .upd_en(upd_en), .upd_sel(upd_sel), .upd_val(upd_val)
  );

  seg_agu_regs #(.W(W)) u_regs (
    .clk(clk), .rst_ok_n(rst_ok_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .upd_en(upd_en), .upd_sel(upd_sel),
    .upd_val(upd_val), .regs_flat(regs_flat)
  );

  seg_agu_addr #(.SEG_W(W), .OFF_W(W), .SHIFT(SHIFT)) u_addr (
    .seg_val(seg_val), .off_val(off_val), .addr(phys_addr)
  );

  always_comb begin
    rd_data = '0;
    if (int'(rd_sel) < NREG) rd_data = regs_flat[int'(rd_sel)*W +: W];
  end

  assign ip_w = regs_flat[RG_IP*W +: W];
  assign sp_w = regs_flat[RG_SP*W +: W];
  assign si_w = regs_flat[RG_SI*W +: W];
  assign di_w = regs_flat[RG_DI*W +: W];
endmodule

// File: rtl/seg_agu_chk.sv
`timescale 1ns/1ps
module seg_agu_chk #(
  parameter int W = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              acc_valid,
  input logic [2:0]        acc_kind,
  input logic              acc_word,
  input logic              dir_down,
  input logic              wr_en,
  input logic [3:0]        wr_sel,
  input logic [W-1:0]      wr_data,
  input logic [W-1:0]      ip,
  input logic [W-1:0]      sp,
  input logic [W-1:0]      si,
  input logic [W-1:0]      di,
  input logic [ADDR_W-1:0] phys_addr
);
  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (acc_valid && acc_kind == 3'd0 && !(wr_en && wr_sel == 4'd4))
      |=> ip == W'($past(ip) + W'(1)));

  p_push_sp_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (acc_valid && acc_kind == 3'd1 && !(wr_en && wr_sel == 4'd5))
      |=> sp == W'($past(sp) - W'(2)));

  p_pop_sp_r3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (acc_valid && acc_kind == 3'd2 && !(wr_en && wr_sel == 4'd5))
      |=> sp == W'($past(sp) + W'(2)));

  p_src_step_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (acc_valid && acc_kind == 3'd5 && !(wr_en && wr_sel == 4'd7))
      |=> si == ($past(dir_down)
                 ? W'($past(si) - ($past(acc_word) ? W'(2) : W'(1)))
                 : W'($past(si) + ($past(acc_word) ? W'(2) : W'(1)))));

  p_write_ip_r8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && wr_sel == 4'd4) |=> ip == $past(wr_data));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!acc_valid && !wr_en) |=> ($stable(ip) && $stable(sp) && $stable(si) && $stable(di)));

  p_none_addr_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!acc_valid || acc_kind == 3'd7) |-> phys_addr == '0);

  p_dst_step_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (acc_valid && acc_kind == 3'd6 && !(wr_en && wr_sel == 4'd8))
      |=> di != $past(di));
endmodule

bind seg_agu seg_agu_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ok_n(rst_ok_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
  .acc_word(acc_word), .dir_down(dir_down), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .ip(ip_w), .sp(sp_w), .si(si_w), .di(di_w),
  .phys_addr(phys_addr)
);

// File: tb/sim_seg_agu.sv
`timescale 1ns/1ps
module sim_seg_agu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_word, dir_down, wr_en;
  logic [2:0]  acc_kind;
  logic [3:0]  wr_sel, rd_sel;
  logic [15:0] wr_data, rd_data;
  logic [19:0] phys_addr;

  int tests = 0;
  int fails = 0;
  logic [15:0] m [10];   // shadow: 0 CS,1 DS,2 SS,3 ES,4 IP,5 SP,6 BP,7 SI,8 DI,9 BX

  always #2 clk = ~clk;  // 250 MHz

  seg_agu u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_word(acc_word), .dir_down(dir_down), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .phys_addr(phys_addr)
  );

  function automatic string req_of(input logic v, input logic [2:0] k);
    if (!v || k == 3'd7) return "R7";
    case (k)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return 20'(({4'b0, s} << 4) + {4'b0, o});
  endfunction

  function automatic logic [19:0] exp_addr(input logic v, input logic [2:0] k);
    if (!v) return 20'h0;
    case (k)
      3'd0: return phys(m[0], m[4]);
      3'd1: return phys(m[2], 16'(m[5] - 16'd2));
      3'd2: return phys(m[2], m[5]);
      3'd3: return phys(m[2], m[6]);
      3'd4: return phys(m[1], m[9]);
      3'd5: return phys(m[1], m[7]);
      3'd6: return phys(m[3], m[8]);
      default: return 20'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 12; i++) begin
      rd_sel = 4'(i);
      #0.1;
      chk(req, {4'h0, rd_data}, (i < 10) ? {4'h0, m[i]} : 20'h0);
    end
  endtask

  // one cycle: drive at negedge, check address and registers, then update shadow
  task automatic op(input logic v, input logic [2:0] k, input logic w, input logic d,
                    input logic we, input logic [3:0] ws, input logic [15:0] wd,
                    input bit regchk);
    logic [15:0] stp;
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_word = w; dir_down = d;
    wr_en = we; wr_sel = ws; wr_data = wd;
    if (regchk) check_regs("R9");
    #0.2;
    chk({req_of(v, k), "/R1"}, phys_addr, exp_addr(v, k));
    @(posedge clk);
    stp = w ? 16'd2 : 16'd1;
    if (v) begin
      case (k)
        3'd0: m[4] = m[4] + 16'd1;
        3'd1: m[5] = m[5] - 16'd2;
        3'd2: m[5] = m[5] + 16'd2;
        3'd5: m[7] = d ? m[7] - stp : m[7] + stp;
        3'd6: m[8] = d ? m[8] - stp : m[8] + stp;
        default: ;
      endcase
    end
    if (we && ws < 4'd10) m[ws] = wd;  // R8: write wins
  endtask

  task automatic wr(input logic [3:0] s, input logic [15:0] d);
    op(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, s, d, 1'b0);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; acc_valid = 0; acc_kind = 0; acc_word = 0; dir_down = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    for (int i = 0; i < 10; i++) m[i] = 16'h0;
    m[0] = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R7: reset state and first fetch at FFFF0
    @(negedge clk);
    check_regs("R7");
    op(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b0);
    chk("R7", phys(16'hFFFF, 16'h0), 20'hFFFF0);

    // R1: 20-bit wrap FFFF:FFFF -> 0FFEF ; R2: IP wrap
    wr(4'd4, 16'hFFFF);
    op(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b1);
    op(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b1);  // IP was 0 after wrap
    chk("R1", exp_addr(1'b1, 3'd0) - 20'h0, phys(16'hFFFF, 16'h1));

    // R3: push at SP=0 wraps to FFFE, then pop back
    wr(4'd2, 16'h1234);
    op(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b1);
    op(1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b1);
    check_regs("R3");

    // R5/R6: SI at 0, downward word step wraps to FFFE; DI byte up
    wr(4'd1, 16'h0400); wr(4'd3, 16'h0800); wr(4'd8, 16'hFFFF);
    op(1'b1, 3'd5, 1'b1, 1'b1, 1'b0, 4'd0, 16'h0, 1'b1);
    op(1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b1);
    op(1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b1);
    op(1'b1, 3'd6, 1'b1, 1'b1, 1'b0, 4'd0, 16'h0, 1'b1);
    check_regs("R6");

    // R4: based and BX accesses leave registers unchanged
    wr(4'd6, 16'hBEEF); wr(4'd9, 16'hCAFE);
    op(1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 4'd0, 16'h0, 1'b1);
    op(1'b1, 3'd4, 1'b1, 1'b1, 1'b0, 4'd0, 16'h0, 1'b1);
    check_regs("R4");

    // R8: write to IP during a fetch wins; codes 10..15 write nothing
    op(1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 4'd4, 16'h5555, 1'b1);
    op(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd12, 16'h7777, 1'b1);
    check_regs("R8");

    // R7: kind 7 has no address and no update
    op(1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 4'd0, 16'h0, 1'b1);
    check_regs("R7");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic we;
      we = ($urandom % 8) == 0;
      op(($urandom % 8) != 0, 3'($urandom), 1'($urandom), 1'($urandom),
         we, 4'($urandom % 12), 16'($urandom), (n % 16) == 0);
    end
    @(negedge clk);
    check_regs("R9");
    finish_run();
  end
endmodule